// File: doc/BRIEF.md
# Horizontal Line-Locked Timing Loop

This block keeps a line-rate timing generator in step with incoming horizontal sync. It runs on a fixed reference clock. Its input is a one-bit sync signal that upstream logic has already filtered and sliced. A numerically controlled oscillator (NCO) adds an increment to a phase accumulator on every reference cycle. Each accumulator carry is one tick of the fastest locked rate. A two-bit sub-counter divides that rate down to a half-rate enable and a base-rate enable. A line counter then divides the base rate down to the line period. A standard-select input sets the line period: 432 base ticks when high (50 Hz lines) and 429 base ticks when low (60 Hz lines).

On each rising sync edge, the block reads the line position from the line counter and the sub-counter, in quarter base ticks. It wraps that position into a signed error centred on line start. A proportional-plus-integral filter with power-of-two gains turns the error into a new NCO increment. The filter keeps that increment until the next edge. A lock monitor raises a flag after a run of edges that land close to line start. It drops the flag on an edge far from line start, or when sync stays silent for one and a half lines.

Top module: `hline_lock_loop`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every output is low, and the increment starts at the NOM_INC parameter.
- R2: While no sync edge arrives, the interval between line_start pulses is LINE_50 (432) base ticks when std_sel is 1 and LINE_60 (429) when std_sel is 0. At the nominal increment this is 4·N·2^ACC_W / NOM_INC reference cycles.
- R3: Within every line there are exactly N base_en pulses, 2N x2_en pulses and 4N x4_en pulses. x2_en is high only together with x4_en, on every second x4 tick. base_en is high only together with x2_en, on every fourth x4 tick.
- R4: line_start is a one-cycle pulse in the reference cycle right after the base_en pulse that completes a line.
- R5: A rising sync edge is measured as the line position in quarter base ticks, counted from line start. Positions below 2N give a positive error. Positions at or above 2N give the position minus 4N, a negative error.
- R6: A sync edge with positive error (sync late against the oscillator) lowers the increment, so following lines get longer. A negative error raises the increment, so following lines get shorter. The change is (err << KP_SHIFT) + (integrator << KI_SHIFT).
- R7: The increment changes only in the cycle after a sync edge has been measured. Between edges, including after sync has gone silent, successive lines have the same length to within one reference cycle.
- R8: The increment stays within NOM_INC ± NOM_INC/8. The integrator saturates at ±INT_LIM.
- R9: locked rises in the cycle after the sixteenth consecutive sync edge whose error magnitude is at most LOCK_TOL quarter ticks. It stays low before that edge.
- R10: A sync edge whose error magnitude exceeds LOCK_TOL clears locked and restarts the run count.
- R11: When N + N/2 base ticks pass with no sync edge, locked is cleared and the run count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Sliced horizontal sync, active high |
| std_sel | input | 1 | Line standard: 1 = 432 base ticks per line, 0 = 429 |
| base_en | output | 1 | Base-rate locked clock enable |
| x2_en | output | 1 | Twice-base-rate locked clock enable |
| x4_en | output | 1 | Four-times-base-rate locked clock enable |
| line_start | output | 1 | One-cycle pulse at the start of each line |
| locked | output | 1 | Loop-in-lock flag |

## Verification
The bench builds the block with ACC_W = 16 and NOM_INC = 49152, which is three quarters of the accumulator range. With these values the fastest tick fires on three of every four reference cycles, and a free-running line lasts exactly 2304 cycles (432) or 2288 cycles (429). Line lengths and enable counts can therefore be compared exactly, and a sixteen-line lock run plus the one-and-a-half-line silence window fit easily in one run. KP_SHIFT = 4 and KI_SHIFT = 0 make a sync placed forty base ticks early or late change the following line length by about five percent. That is large enough to show the sign of the correction and that the increment is held between edges.

// File: rtl/hll_pkg.sv
package hll_pkg;

    typedef enum logic {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } line_std_e;

    // Line length in base ticks for the selected standard.
    function automatic logic [31:0] pick_len(input line_std_e std,
                                             input int unsigned n50,
                                             input int unsigned n60);
        return (std == STD_50) ? n50 : n60;
    endfunction

endpackage

// File: rtl/hll_nco.sv
module hll_nco #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_i,
    output logic             x4_o,
    output logic             x2_o,
    output logic             base_o,
    output logic [1:0]       sub_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [1:0]       sub;
        logic             x4;
        logic             x2;
        logic             base;
    } nco_st_t;

    nco_st_t          nco_q, nco_d;
    logic [ACC_W:0]   sum;

    always_comb begin
        nco_d      = nco_q;
        sum        = {1'b0, nco_q.acc} + {1'b0, inc_i};
        nco_d.acc  = sum[ACC_W-1:0];
        nco_d.x4   = sum[ACC_W];
        // half rate: every second carry, base rate: every fourth carry
        nco_d.x2   = sum[ACC_W] & nco_q.sub[0];
        nco_d.base = sum[ACC_W] & (nco_q.sub == 2'd3);
        if (sum[ACC_W]) begin
            nco_d.sub = nco_q.sub + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nco_q <= '0;
        end else begin
            nco_q <= nco_d;
        end
    end

    assign x4_o   = nco_q.x4;
    assign x2_o   = nco_q.x2;
    assign base_o = nco_q.base;
    assign sub_o  = nco_q.sub;

endmodule

// File: rtl/hll_line_timer.sv
module hll_line_timer
    import hll_pkg::*;
#(
    parameter int unsigned LINE_50 = 432,
    parameter int unsigned LINE_60 = 429,
    parameter int          CNT_W   = 9,
    parameter int          ERR_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    std_sel,
    input  logic                    base_tick,
    input  logic [1:0]              sub_i,
    input  logic                    sync_i,
    output logic                    line_start_o,
    output logic                    edge_o,
    output logic signed [ERR_W-1:0] err_o
);

    localparam int PH_W = CNT_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       sub_dly;
        logic             s1;
        logic             s2;
        logic             start;
        logic             edge_v;
        logic [ERR_W-1:0] err;
    } lt_st_t;

    lt_st_t            lt_q, lt_d;
    logic [31:0]       len;
    logic [CNT_W-1:0]  last;
    logic [PH_W-1:0]   phase;
    logic [PH_W-1:0]   half;
    logic [ERR_W-1:0]  full;
    logic [ERR_W-1:0]  ext;
    logic              rise;

    always_comb begin
        lt_d    = lt_q;
        len     = pick_len(line_std_e'(std_sel), LINE_50, LINE_60);
        last    = CNT_W'(len - 32'd1);
        half    = PH_W'(len * 32'd2);
        full    = ERR_W'(len * 32'd4);

        // line counter, clocked by the base enable
        lt_d.start = 1'b0;
        if (base_tick) begin
            if (lt_q.cnt >= last) begin
                lt_d.cnt   = '0;
                lt_d.start = 1'b1;
            end else begin
                lt_d.cnt = lt_q.cnt + CNT_W'(1);
            end
        end

        // sub-counter delayed so it moves in step with the line counter
        lt_d.sub_dly = sub_i;

        // sync edge detection
        lt_d.s1 = sync_i;
        lt_d.s2 = lt_q.s1;
        rise    = lt_q.s1 & ~lt_q.s2;

        // phase in quarter base ticks, wrapped around line start
        phase       = {lt_q.cnt, lt_q.sub_dly};
        ext         = {1'b0, phase};
        lt_d.edge_v = rise;
        if (rise) begin
            lt_d.err = (phase < half) ? ext : (ext - full);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lt_q <= '0;
        end else begin
            lt_q <= lt_d;
        end
    end

    assign line_start_o = lt_q.start;
    assign edge_o       = lt_q.edge_v;
    assign err_o        = $signed(lt_q.err);

endmodule

// File: rtl/hll_loop_filter.sv
module hll_loop_filter #(
    parameter int          ACC_W    = 24,
    parameter int          ERR_W    = 12,
    parameter int unsigned NOM_INC  = 2264924,
    parameter int          KP_SHIFT = 9,
    parameter int          KI_SHIFT = 5,
    parameter int          INT_W    = 14,
    parameter int unsigned INT_LIM  = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    edge_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic [ACC_W-1:0]        inc_o,
    output logic signed [INT_W-1:0] integ_o
);

    localparam int CW = ACC_W + ERR_W + INT_W + KP_SHIFT + KI_SHIFT + 2;
    localparam logic signed [CW-1:0] NOM_S  = CW'(NOM_INC);
    localparam logic signed [CW-1:0] SPAN_S = CW'(NOM_INC / 8);
    localparam logic signed [CW-1:0] LIM_S  = CW'(INT_LIM);

    typedef struct packed {
        logic [ACC_W-1:0] inc;
        logic [INT_W-1:0] integ;
    } lf_st_t;

    localparam lf_st_t LF_RST = '{inc: ACC_W'(NOM_INC), integ: '0};

    lf_st_t                 lf_q, lf_d;
    logic signed [CW-1:0]   err_x, int_x, i_sum, i_sat;
    logic signed [CW-1:0]   p_term, i_term, inc_raw, inc_cl;

    always_comb begin
        lf_d  = lf_q;
        err_x = CW'($signed(err_i));
        int_x = CW'($signed(lf_q.integ));

        // integrating term with anti-windup clamp
        i_sum = int_x + err_x;
        if (i_sum > LIM_S) begin
            i_sat = LIM_S;
        end else if (i_sum < -LIM_S) begin
            i_sat = -LIM_S;
        end else begin
            i_sat = i_sum;
        end

        p_term  = err_x <<< KP_SHIFT;
        i_term  = i_sat <<< KI_SHIFT;
        inc_raw = NOM_S - p_term - i_term;

        if (inc_raw > NOM_S + SPAN_S) begin
            inc_cl = NOM_S + SPAN_S;
        end else if (inc_raw < NOM_S - SPAN_S) begin
            inc_cl = NOM_S - SPAN_S;
        end else begin
            inc_cl = inc_raw;
        end

        if (edge_i) begin
            lf_d.integ = i_sat[INT_W-1:0];
            lf_d.inc   = inc_cl[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lf_q <= LF_RST;
        end else begin
            lf_q <= lf_d;
        end
    end

    assign inc_o   = lf_q.inc;
    assign integ_o = $signed(lf_q.integ);

endmodule

// File: rtl/hll_lock_mon.sv
module hll_lock_mon
    import hll_pkg::*;
#(
    parameter int unsigned LINE_50    = 432,
    parameter int unsigned LINE_60    = 429,
    parameter int          ERR_W      = 12,
    parameter int unsigned LOCK_LINES = 16,
    parameter int unsigned LOCK_TOL   = 8,
    parameter int          TMO_W      = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    std_sel,
    input  logic                    base_tick,
    input  logic                    edge_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic                    locked_o
);

    localparam int GC_W = $clog2(LOCK_LINES + 1);

    typedef struct packed {
        logic [GC_W-1:0]  good;
        logic [TMO_W-1:0] tmo;
        logic             locked;
    } lm_st_t;

    lm_st_t            lm_q, lm_d;
    logic [31:0]       len;
    logic [TMO_W-1:0]  lim;
    logic [ERR_W-1:0]  eb;
    logic [ERR_W-1:0]  mag;
    logic              in_tol;

    always_comb begin
        lm_d   = lm_q;
        len    = pick_len(line_std_e'(std_sel), LINE_50, LINE_60);
        lim    = TMO_W'(len + len / 32'd2);
        eb     = err_i;
        mag    = eb[ERR_W-1] ? (ERR_W'(0) - eb) : eb;
        in_tol = (mag <= ERR_W'(LOCK_TOL));

        if (edge_i) begin
            lm_d.tmo = '0;
            if (in_tol) begin
                if (lm_q.good < GC_W'(LOCK_LINES)) begin
                    lm_d.good = lm_q.good + GC_W'(1);
                end
                lm_d.locked = (lm_d.good >= GC_W'(LOCK_LINES));
            end else begin
                lm_d.good   = '0;
                lm_d.locked = 1'b0;
            end
        end else if (base_tick && (lm_q.tmo < lim)) begin
            lm_d.tmo = lm_q.tmo + TMO_W'(1);
            if (lm_d.tmo >= lim) begin
                lm_d.good   = '0;
                lm_d.locked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lm_q <= '0;
        end else begin
            lm_q <= lm_d;
        end
    end

    assign locked_o = lm_q.locked;

endmodule

// File: rtl/hline_lock_loop.sv
module hline_lock_loop #(
    parameter int          ACC_W      = 24,
    parameter int unsigned NOM_INC    = 2264924,
    parameter int unsigned LINE_50    = 432,
    parameter int unsigned LINE_60    = 429,
    parameter int          KP_SHIFT   = 9,
    parameter int          KI_SHIFT   = 5,
    parameter int unsigned INT_LIM    = 4096,
    parameter int unsigned LOCK_LINES = 16,
    parameter int unsigned LOCK_TOL   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic std_sel,
    output logic base_en,
    output logic x2_en,
    output logic x4_en,
    output logic line_start,
    output logic locked
);

    localparam int unsigned LINE_MAX = (LINE_50 > LINE_60) ? LINE_50 : LINE_60;
    localparam int CNT_W = $clog2(LINE_MAX);
    localparam int ERR_W = CNT_W + 3;
    localparam int INT_W = $clog2(INT_LIM + 1) + 1;
    localparam int TMO_W = $clog2(LINE_MAX + LINE_MAX / 2 + 1);

    logic [ACC_W-1:0]        nco_inc;
    logic [1:0]              nco_sub;
    logic                    edge_v;
    logic signed [ERR_W-1:0] ph_err;
    logic signed [INT_W-1:0] filt_integ;

    hll_nco #(
        .ACC_W (ACC_W)
    ) u_nco (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (nco_inc),
        .x4_o   (x4_en),
        .x2_o   (x2_en),
        .base_o (base_en),
        .sub_o  (nco_sub)
    );

    hll_line_timer #(
        .LINE_50 (LINE_50),
        .LINE_60 (LINE_60),
        .CNT_W   (CNT_W),
        .ERR_W   (ERR_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .std_sel      (std_sel),
        .base_tick    (base_en),
        .sub_i        (nco_sub),
        .sync_i       (sync_in),
        .line_start_o (line_start),
        .edge_o       (edge_v),
        .err_o        (ph_err)
    );

    hll_loop_filter #(
        .ACC_W    (ACC_W),
        .ERR_W    (ERR_W),
        .NOM_INC  (NOM_INC),
        .KP_SHIFT (KP_SHIFT),
        .KI_SHIFT (KI_SHIFT),
        .INT_W    (INT_W),
        .INT_LIM  (INT_LIM)
    ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_i  (edge_v),
        .err_i   (ph_err),
        .inc_o   (nco_inc),
        .integ_o (filt_integ)
    );

    hll_lock_mon #(
        .LINE_50    (LINE_50),
        .LINE_60    (LINE_60),
        .ERR_W      (ERR_W),
        .LOCK_LINES (LOCK_LINES),
        .LOCK_TOL   (LOCK_TOL),
        .TMO_W      (TMO_W)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .std_sel   (std_sel),
        .base_tick (base_en),
        .edge_i    (edge_v),
        .err_i     (ph_err),
        .locked_o  (locked)
    );

endmodule

// File: rtl/hll_checker.sv
module hll_checker #(
    parameter int          ACC_W   = 24,
    parameter int unsigned NOM_INC = 2264924,
    parameter int          INT_W   = 14,
    parameter int unsigned INT_LIM = 4096
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    x4_en,
    input logic                    x2_en,
    input logic                    base_en,
    input logic                    line_start,
    input logic                    locked,
    input logic                    edge_v,
    input logic [ACC_W-1:0]        inc,
    input logic signed [INT_W-1:0] integ
);

    localparam logic [ACC_W:0] INC_LO = (ACC_W+1)'(NOM_INC - NOM_INC / 8);
    localparam logic [ACC_W:0] INC_HI = (ACC_W+1)'(NOM_INC + NOM_INC / 8);
    localparam logic signed [INT_W-1:0] LIM_P = INT_W'(INT_LIM);

    assert_x2_on_x4_R3: assert property (@(posedge clk) disable iff (!rst_n)
        x2_en |-> x4_en);

    assert_base_on_x2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        base_en |-> x2_en);

    assert_start_after_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> $past(base_en));

    assert_inc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_v |=> $stable(inc));

    assert_inc_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, inc} >= INC_LO) && ({1'b0, inc} <= INC_HI));

    assert_integ_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (integ <= LIM_P) && (integ >= -LIM_P));

    assert_lock_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(edge_v));

endmodule

bind hline_lock_loop hll_checker #(
    .ACC_W   (ACC_W),
    .NOM_INC (NOM_INC),
    .INT_W   (INT_W),
    .INT_LIM (INT_LIM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .x4_en      (x4_en),
    .x2_en      (x2_en),
    .base_en    (base_en),
    .line_start (line_start),
    .locked     (locked),
    .edge_v     (edge_v),
    .inc        (nco_inc),
    .integ      (filt_integ)
);

// File: tb/hline_lock_loop_test.sv
module hline_lock_loop_test;

    localparam int          TB_ACC_W = 16;
    localparam int unsigned TB_NOM   = 49152;
    localparam int          L50      = 432;
    localparam int          L60      = 429;
    localparam int          CYC50    = L50 * 4 * (1 << TB_ACC_W) / TB_NOM;   // 2304
    localparam int          OFFS     = 213;                                   // ~40 base ticks
    localparam int          TMO_CYC  = (L50 + L50 / 2) * 4 * (1 << TB_ACC_W) / TB_NOM;

    typedef struct packed {
        logic        std;
        logic [15:0] len;
    } vec_t;

    localparam vec_t VECS [3] = '{
        '{std: 1'b1, len: 16'(L50)},
        '{std: 1'b0, len: 16'(L60)},
        '{std: 1'b1, len: 16'(L50)}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic std_sel = 1'b1;
    logic base_en, x2_en, x4_en, line_start, locked;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hline_lock_loop #(
        .ACC_W    (TB_ACC_W),
        .NOM_INC  (TB_NOM),
        .KP_SHIFT (4),
        .KI_SHIFT (0)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .std_sel    (std_sel),
        .base_en    (base_en),
        .x2_en      (x2_en),
        .x4_en      (x4_en),
        .line_start (line_start),
        .locked     (locked)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        sync_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ls();
        do @(negedge clk); while (!line_start);
    endtask

    // Called at a negedge where line_start is high; returns at the next one.
    task automatic measure(output int cyc, output int nb, output int n2,
                           output int n4, output bit base_before);
        logic prev_base;
        cyc = 0; nb = 0; n2 = 0; n4 = 0;
        prev_base = 1'b0;
        base_before = 1'b0;
        do begin
            prev_base = base_en;
            @(negedge clk);
            cyc++;
            nb += int'(base_en);
            n2 += int'(x2_en);
            n4 += int'(x4_en);
            if (line_start) base_before = prev_base;
        end while (!line_start);
    endtask

    task automatic pulse_sync();
        sync_in = 1'b1;
        repeat (16) @(negedge clk);
        sync_in = 1'b0;
    endtask

    // Sixteen sync edges, each aligned with line start, one line apart.
    task automatic lock_run(input bit chk);
        wait_ls();
        for (int k = 1; k <= 16; k++) begin
            pulse_sync();
            repeat (100) @(negedge clk);
            if (chk) check("R9 lock run", locked == (k == 16), longint'(locked), longint'(k == 16));
            repeat (CYC50 - 116) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int cyc, nb, n2, n4, p1, p2, exp_cyc;
        bit bb;

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", {base_en, x2_en, x4_en, line_start, locked} == 5'b0,
              longint'({base_en, x2_en, x4_en, line_start, locked}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after release", {base_en, x2_en, x4_en, line_start, locked} == 5'b0,
              longint'({base_en, x2_en, x4_en, line_start, locked}), 0);

        // Vector walk: free-running line length and enable counts per standard
        for (int v = 0; v < 3; v++) begin
            std_sel = VECS[v].std;
            wait_ls();
            wait_ls();
            measure(cyc, nb, n2, n4, bb);
            exp_cyc = int'(VECS[v].len) * 4 * (1 << TB_ACC_W) / TB_NOM;
            check("R2 line cycles", cyc == exp_cyc, cyc, exp_cyc);
            check("R3 base count", nb == int'(VECS[v].len), nb, int'(VECS[v].len));
            check("R3 x2 count", n2 == 2 * int'(VECS[v].len), n2, 2 * int'(VECS[v].len));
            check("R3 x4 count", n4 == 4 * int'(VECS[v].len), n4, 4 * int'(VECS[v].len));
            check("R4 base before start", bb == 1'b1, longint'(bb), 1);
        end

        // Lock acquisition, then silence
        std_sel = 1'b1;
        do_reset();
        lock_run(1'b1);
        // now CYC50 cycles after the last sync rise
        repeat (TMO_CYC - 250 - CYC50) @(negedge clk);
        check("R11 still locked before window", locked == 1'b1, longint'(locked), 1);
        repeat (500) @(negedge clk);
        check("R11 lock lost after 1.5 lines", locked == 1'b0, longint'(locked), 0);

        // Lock then a far-off edge
        do_reset();
        lock_run(1'b0);
        repeat (700) @(negedge clk);
        check("R9 locked before bad edge", locked == 1'b1, longint'(locked), 1);
        pulse_sync();
        repeat (24) @(negedge clk);
        check("R10 bad edge clears lock", locked == 1'b0, longint'(locked), 0);

        // Late sync: positive error lengthens lines, then increment held
        do_reset();
        wait_ls();
        repeat (OFFS) @(negedge clk);
        pulse_sync();
        wait_ls();
        measure(p1, nb, n2, n4, bb);
        measure(p2, nb, n2, n4, bb);
        check("R6 late sync longer line", p1 > CYC50 + 50, p1, CYC50 + 50);
        check("R7 held after late sync", (p1 - p2 <= 1) && (p2 - p1 <= 1), p2, p1);

        // Early sync: wrapped negative error (R5) shortens lines
        do_reset();
        wait_ls();
        repeat (CYC50 - OFFS) @(negedge clk);
        pulse_sync();
        wait_ls();
        measure(p1, nb, n2, n4, bb);
        measure(p2, nb, n2, n4, bb);
        check("R5 R6 early sync shorter line", p1 < CYC50 - 50, p1, CYC50 - 50);
        check("R7 held after early sync", (p1 - p2 <= 1) && (p2 - p1 <= 1), p2, p1);

        report();
    end

endmodule